// File: doc/BRIEF.md
# Paged ROM Program Sequencer

This block produces the instruction fetch address for a small 4-bit controller whose program ROM is split into 16 pages of 64 words. The address is a page number concatenated with a word index. Sequential fetches advance the word index and never leave the current page. Changing page takes two instructions. The first loads the target page into a staging buffer. A later branch or call then copies that buffer into the page register and loads the word index from its 6-bit operand.

A two-level return stack is included. A call saves both the page and the word that follows the call. A return restores both, so control can return to a different page. If the stack overflows or underflows, a sticky fault flag is set and stays set until reset.

The sequencer is driven by a fetch strobe and by one-cycle strobes from the instruction decoder. Every address change is registered and appears on the output after the clock edge that accepts the strobe.

Top module: `paged_seq_top`

## Requirements
- R1: After reset, the address output is 0 (page 0, word 0) and the fault flag is 0. The page buffer is also 0, so a branch issued straight after reset lands in page 0.
- R2: The output address is `{page[3:0], word[5:0]}`. When fetch is high and no branch, call or return strobe is active, the word index increases by 1 at the next edge and the page stays the same. With no strobe and no fetch, the address holds.
- R3: After word 63, a fetch gives word 0 in the same page.
- R4: Load-page-buffer stores the 4-bit immediate in the buffer and does not change the output address.
- R5: A branch copies the buffer into the page register and loads the word from the operand. No increment happens in that cycle, even when fetch is high.
- R6: The buffer keeps its value after a branch or call, so a later branch with no reload goes to the same page.
- R7: A call jumps in the same way as a branch. It also pushes the current page and the word after the call, computed modulo 64.
- R8: A return loads both page and word from the top stack entry. This can change the page, and no increment happens in that cycle.
- R9: Two nested calls return in last-in, first-out order.
- R10: A third nested call discards the oldest entry and sets the sticky fault flag. The later returns give the two newest entries.
- R11: A return with an empty stack reloads the entry popped most recently (0/0 if nothing has been pushed since reset) and sets the fault flag. Once set, the flag stays at 1 until reset.
- R12: When several control strobes are active in the same cycle, return takes precedence over call, and call takes precedence over branch.
- R13: When load-page-buffer and a branch come in the same cycle, the branch uses the old buffer value. The new value takes effect for the next branch or call.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_i | input | 1 | Instruction fetch strobe |
| ld_pbuf_i | input | 1 | Load page buffer strobe |
| branch_i | input | 1 | Branch strobe |
| call_i | input | 1 | Call strobe |
| return_i | input | 1 | Return strobe |
| page_imm_i | input | 4 | Page immediate for the buffer load |
| word_op_i | input | 6 | Target word operand for branch and call |
| rom_addr_o | output | 10 | ROM address `{page, word}` |
| stack_fault_o | output | 1 | Sticky flag for stack overflow or underflow |

## Verification
A page register or buffer that is wrong inside the block stays hidden until the next branch, call or return. After that edge, the page field of the address is wrong, so a test must follow each buffer load with a jump. A corrupted stack entry shows up only when it is popped, which can be several calls later. A shift-order error therefore needs full nest-and-unwind sequences, including overflow and underflow, before the address and the fault flag show it.

// File: rtl/paged_seq_pkg.sv
package paged_seq_pkg;
  localparam int unsigned PAGE_W      = 4;
  localparam int unsigned WORD_W      = 6;
  localparam int unsigned ADDR_W      = PAGE_W + WORD_W;
  localparam int unsigned STACK_DEPTH = 2;

  typedef struct packed {
    logic [PAGE_W-1:0] page;
    logic [WORD_W-1:0] word;
  } ret_entry_t;

  typedef enum logic [1:0] {
    FLOW_SEQ  = 2'd0,
    FLOW_JUMP = 2'd1,
    FLOW_CALL = 2'd2,
    FLOW_RET  = 2'd3
  } flow_e;
endpackage

// File: rtl/seq_flow_dec.sv
module seq_flow_dec
  import paged_seq_pkg::*;
(
  input  logic  branch_i,
  input  logic  call_i,
  input  logic  return_i,
  output flow_e flow_o
);
  // return > call > branch
  always_comb begin
    if (return_i)      flow_o = FLOW_RET;
    else if (call_i)   flow_o = FLOW_CALL;
    else if (branch_i) flow_o = FLOW_JUMP;
    else               flow_o = FLOW_SEQ;
  end
endmodule

// File: rtl/seq_page_unit.sv
module seq_page_unit
  import paged_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_pbuf_i,
  input  logic [PAGE_W-1:0] page_imm_i,
  input  flow_e             flow_i,
  input  logic [PAGE_W-1:0] ret_page_i,
  output logic [PAGE_W-1:0] page_o
);
  logic [PAGE_W-1:0] pbuf_q, page_q, page_d;

  always_comb begin
    unique case (flow_i)
      FLOW_JUMP, FLOW_CALL: page_d = pbuf_q;
      FLOW_RET:             page_d = ret_page_i;
      default:              page_d = page_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pbuf_q <= '0;
      page_q <= '0;
    end else begin
      page_q <= page_d;
      if (ld_pbuf_i) pbuf_q <= page_imm_i;
    end
  end

  assign page_o = page_q;
endmodule

// File: rtl/seq_word_ctr.sv
module seq_word_ctr
  import paged_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_i,
  input  flow_e             flow_i,
  input  logic [WORD_W-1:0] word_op_i,
  input  logic [WORD_W-1:0] ret_word_i,
  output logic [WORD_W-1:0] word_o,
  output logic [WORD_W-1:0] word_next_o
);
  logic [WORD_W-1:0] word_q, word_d;

  assign word_next_o = word_q + WORD_W'(1);  // wraps inside page

  always_comb begin
    unique case (flow_i)
      FLOW_JUMP, FLOW_CALL: word_d = word_op_i;
      FLOW_RET:             word_d = ret_word_i;
      default:              word_d = fetch_i ? word_next_o : word_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_q <= '0;
    else         word_q <= word_d;
  end

  assign word_o = word_q;
endmodule

// File: rtl/seq_ret_stack.sv
module seq_ret_stack
  import paged_seq_pkg::*;
#(
  parameter int unsigned DEPTH = STACK_DEPTH
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       push_i,
  input  logic       pop_i,
  input  ret_entry_t push_data_i,
  output ret_entry_t top_o,
  output logic       fault_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  ret_entry_t       ent_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic             full, empty, fault_q, shift_up;

  assign full     = (cnt_q == CNT_W'(DEPTH));
  assign empty    = (cnt_q == '0);
  // with one entry left the top is kept, so an empty pop reuses it
  assign shift_up = pop_i && (cnt_q > CNT_W'(1));

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q[i] <= '0;
      end else if (push_i) begin
        if (i == 0) ent_q[i] <= push_data_i;
        else        ent_q[i] <= ent_q[(i == 0) ? 0 : i-1];
      end else if (shift_up && (i < DEPTH-1)) begin
        ent_q[i] <= ent_q[(i < DEPTH-1) ? i+1 : i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      if (push_i && !full)      cnt_q <= cnt_q + CNT_W'(1);
      else if (pop_i && !empty) cnt_q <= cnt_q - CNT_W'(1);
      if ((push_i && full) || (pop_i && empty)) fault_q <= 1'b1;
    end
  end

  assign top_o   = ent_q[0];
  assign fault_o = fault_q;
endmodule

// File: rtl/paged_seq_top.sv
module paged_seq_top
  import paged_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_i,
  input  logic              ld_pbuf_i,
  input  logic              branch_i,
  input  logic              call_i,
  input  logic              return_i,
  input  logic [PAGE_W-1:0] page_imm_i,
  input  logic [WORD_W-1:0] word_op_i,
  output logic [ADDR_W-1:0] rom_addr_o,
  output logic              stack_fault_o
);
  flow_e             flow;
  ret_entry_t        top_ent, push_ent;
  logic [PAGE_W-1:0] page;
  logic [WORD_W-1:0] word, word_next;

  seq_flow_dec u_dec (
    .branch_i (branch_i),
    .call_i   (call_i),
    .return_i (return_i),
    .flow_o   (flow)
  );

  seq_page_unit u_page (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ld_pbuf_i  (ld_pbuf_i),
    .page_imm_i (page_imm_i),
    .flow_i     (flow),
    .ret_page_i (top_ent.page),
    .page_o     (page)
  );

  seq_word_ctr u_word (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fetch_i     (fetch_i),
    .flow_i      (flow),
    .word_op_i   (word_op_i),
    .ret_word_i  (top_ent.word),
    .word_o      (word),
    .word_next_o (word_next)
  );

  assign push_ent = '{page: page, word: word_next};

  seq_ret_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (flow == FLOW_CALL),
    .pop_i       (flow == FLOW_RET),
    .push_data_i (push_ent),
    .top_o       (top_ent),
    .fault_o     (stack_fault_o)
  );

  assign rom_addr_o = {page, word};
endmodule

// File: rtl/paged_seq_chk.sv
module paged_seq_chk
  import paged_seq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fetch_i,
  input logic              ld_pbuf_i,
  input logic              branch_i,
  input logic              call_i,
  input logic              return_i,
  input logic [WORD_W-1:0] word_op_i,
  input logic [ADDR_W-1:0] rom_addr_o,
  input logic              stack_fault_o
);
  logic no_flow;
  assign no_flow = !branch_i && !call_i && !return_i;

  // R2
  seq_incr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_i && no_flow) |=>
      (rom_addr_o[WORD_W-1:0] == WORD_W'($past(rom_addr_o[WORD_W-1:0]) + WORD_W'(1)))
      && (rom_addr_o[ADDR_W-1:WORD_W] == $past(rom_addr_o[ADDR_W-1:WORD_W])));

  // R4
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fetch_i && no_flow) |=> $stable(rom_addr_o));

  // R5
  branch_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (branch_i && !call_i && !return_i) |=> (rom_addr_o[WORD_W-1:0] == $past(word_op_i)));

  // R7
  call_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && !return_i) |=> (rom_addr_o[WORD_W-1:0] == $past(word_op_i)));

  // R11
  fault_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stack_fault_o |=> stack_fault_o);

  // R11
  fault_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stack_fault_o) |-> $past(call_i || return_i));

  logic unused;
  assign unused = ld_pbuf_i;
endmodule

bind paged_seq_top paged_seq_chk chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .fetch_i       (fetch_i),
  .ld_pbuf_i     (ld_pbuf_i),
  .branch_i      (branch_i),
  .call_i        (call_i),
  .return_i      (return_i),
  .word_op_i     (word_op_i),
  .rom_addr_o    (rom_addr_o),
  .stack_fault_o (stack_fault_o)
);

// File: tb/paged_seq_top_tb_top.sv
module paged_seq_top_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fetch_i = 1'b0, ld_pbuf_i = 1'b0, branch_i = 1'b0;
  logic       call_i = 1'b0, return_i = 1'b0;
  logic [3:0] page_imm_i = '0;
  logic [5:0] word_op_i = '0;
  logic [9:0] rom_addr_o;
  logic       stack_fault_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #5 clk_i = ~clk_i;

  paged_seq_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .fetch_i(fetch_i), .ld_pbuf_i(ld_pbuf_i),
    .branch_i(branch_i), .call_i(call_i), .return_i(return_i),
    .page_imm_i(page_imm_i), .word_op_i(word_op_i),
    .rom_addr_o(rom_addr_o), .stack_fault_o(stack_fault_o)
  );

  function automatic logic [9:0] pa(input int pg, input int wd);
    return 10'(pg * 64 + wd);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one cycle of strobes, sampled 1 ns after the edge
  task automatic step(input logic f, input logic ld, input logic br, input logic cl,
                      input logic rt, input int pimm, input int wop);
    fetch_i = f; ld_pbuf_i = ld; branch_i = br; call_i = cl; return_i = rt;
    page_imm_i = 4'(pimm); word_op_i = 6'(wop);
    @(posedge clk_i); #1;
    fetch_i = 0; ld_pbuf_i = 0; branch_i = 0; call_i = 0; return_i = 0;
  endtask

  task automatic do_reset();
    rst_ni = 0;
    repeat (2) @(posedge clk_i);
    #3 rst_ni = 1;
    #1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 addr", rom_addr_o, 0);
    chk("R1 fault", stack_fault_o, 0);
    step(0, 0, 1, 0, 0, 0, 5);
    chk("R1 buffer zero", rom_addr_o, pa(0, 5));
    do_reset();
  endtask

  task automatic t_fetch();
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0, 0);
    chk("R2 incr", rom_addr_o, 3);
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R2 hold", rom_addr_o, 3);
  endtask

  task automatic t_wrap();
    step(0, 1, 0, 0, 0, 5, 0);
    step(0, 0, 1, 0, 0, 0, 62);
    chk("R5 branch", rom_addr_o, pa(5, 62));
    step(1, 0, 0, 0, 0, 0, 0);
    chk("R3 to 63", rom_addr_o, pa(5, 63));
    step(1, 0, 0, 0, 0, 0, 0);
    chk("R3 wrap", rom_addr_o, pa(5, 0));
  endtask

  task automatic t_buffer();
    step(0, 1, 0, 0, 0, 9, 0);
    chk("R4 ld no effect", rom_addr_o, pa(5, 0));
    step(1, 0, 1, 0, 0, 0, 1);
    chk("R5 no incr", rom_addr_o, pa(9, 1));
    step(0, 0, 1, 0, 0, 0, 10);
    chk("R6 reuse buffer", rom_addr_o, pa(9, 10));
    step(0, 1, 1, 0, 0, 3, 4);
    chk("R13 old buffer", rom_addr_o, pa(9, 4));
    step(0, 0, 1, 0, 0, 0, 0);
    chk("R13 new buffer", rom_addr_o, pa(3, 0));
  endtask

  task automatic t_nest();
    step(1, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 7, 0);
    step(1, 0, 0, 1, 0, 0, 5);
    chk("R7 call", rom_addr_o, pa(7, 5));
    step(1, 0, 0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 12, 0);
    step(0, 0, 0, 1, 0, 0, 63);
    chk("R7 call 2", rom_addr_o, pa(12, 63));
    step(1, 0, 0, 0, 1, 0, 0);
    chk("R8 return cross page", rom_addr_o, pa(7, 7));
    step(0, 0, 0, 0, 1, 0, 0);
    chk("R9 lifo", rom_addr_o, pa(3, 3));
    chk("R9 no fault", stack_fault_o, 0);
    step(0, 1, 0, 0, 0, 2, 0);
    step(0, 0, 1, 0, 0, 0, 63);
    step(0, 0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0);
    chk("R7 push wrap", rom_addr_o, pa(2, 0));
  endtask

  task automatic t_prio();
    step(0, 1, 0, 0, 0, 4, 0);
    step(0, 0, 0, 1, 0, 0, 8);
    chk("R12 call", rom_addr_o, pa(4, 8));
    step(0, 0, 1, 1, 0, 0, 20);
    chk("R12 call over branch", rom_addr_o, pa(4, 20));
    step(0, 0, 1, 1, 1, 0, 30);
    chk("R12 return over call", rom_addr_o, pa(4, 9));
    step(0, 0, 0, 0, 1, 0, 0);
    chk("R12 unwind", rom_addr_o, pa(2, 1));
    chk("R12 no fault", stack_fault_o, 0);
  endtask

  task automatic t_overflow();
    do_reset();
    step(0, 1, 0, 0, 0, 1, 0);
    step(0, 0, 0, 1, 0, 0, 1);
    step(0, 0, 0, 1, 0, 0, 2);
    chk("R10 no fault yet", stack_fault_o, 0);
    step(0, 0, 0, 1, 0, 0, 3);
    chk("R10 fault", stack_fault_o, 1);
    step(0, 0, 0, 0, 1, 0, 0);
    chk("R10 ret1", rom_addr_o, pa(1, 3));
    step(0, 0, 0, 0, 1, 0, 0);
    chk("R10 ret2", rom_addr_o, pa(1, 2));
    step(0, 0, 0, 0, 1, 0, 0);
    chk("R11 empty reload", rom_addr_o, pa(1, 2));
    step(1, 0, 0, 0, 0, 0, 0);
    chk("R11 sticky", stack_fault_o, 1);
  endtask

  task automatic t_underflow();
    do_reset();
    step(1, 0, 0, 0, 0, 0, 0);
    chk("R11 pre", stack_fault_o, 0);
    step(0, 0, 0, 0, 1, 0, 0);
    chk("R11 empty at reset", rom_addr_o, 0);
    chk("R11 fault", stack_fault_o, 1);
  endtask

  initial begin
    while (cycles < 20000) begin
      @(posedge clk_i);
      cycles++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=<20000", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_fetch();
    t_wrap();
    t_buffer();
    t_nest();
    t_prio();
    t_overflow();
    t_underflow();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule